// File: doc/BRIEF.md
# Two-Way Virtually Indexed, Physically Tagged Cache Lookup Stage

This block is the lookup stage of a data cache. It starts reading its tag and line arrays from the page-offset bits of a virtual address, in the cycle the request is accepted. The translation of the page number runs alongside in a separate unit. When that unit returns a physical page number, the stage compares the number against the tags it read and answers with a hit and the requested 32-bit word, with a protection fault, or with a miss. The lowest 15 address bits are never translated, because they sit inside a page of at least 32 KB. The 9 set-index bits and the 6 byte-in-line bits both come from that field, so the array read never waits for translation.

The cache has two ways of 512 sets, each set holding 64-byte lines, which gives 64 KB in total. Each stored tag is the 17-bit physical page number. Two virtual addresses that translate to the same physical page, with the same offset, therefore find the same line. On a miss the stage requests a line refill at the physical line address. When the line arrives it is written into the least recently used way of the set, and the stage becomes ready again. The requester then reissues the access and hits. A translation that arrives late holds the array outputs in registers and stalls the stage.

Top module: `vipt_cache_lookup`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` and `refill_req` are 0, and every line is invalid, so the first access to any set misses.
- R2: The set index is `req_vaddr[14:6]`. The returned word is word number `req_vaddr[5:2]` of the line, where word k occupies bits [32k+31:32k] of the refilled line.
- R3: A request is accepted when `req_valid` and `req_ready` are both 1. `resp_valid` rises in the first cycle after acceptance in which `xlat_valid` is 1, at the earliest one cycle after acceptance. It lasts that single cycle.
- R4: While translation has not answered, `resp_valid` stays 0, `req_ready` stays 0 and the array outputs read at acceptance are held.
- R5: `resp_hit` is 1 exactly when a valid way of the set holds a tag equal to `xlat_ppn`. Virtual page bits never take part in the compare, so two virtual addresses with equal low 15 bits and the same physical page hit the same line.
- R6: When `xlat_fault` is 1 the response has `resp_fault`=1 and `resp_hit`=0, no refill is requested, the stored state is unchanged, and the stage is ready in the next cycle.
- R7: On a miss (`resp_valid`=1, `resp_hit`=0, `resp_fault`=0) the stage raises `refill_req` in the next cycle. `refill_paddr` = {ppn, vaddr[14:6], 6'b0}, and both signals hold steady until `refill_valid` is 1. `req_ready` stays 0 meanwhile.
- R8: The cycle with `refill_valid`=1 writes `refill_data` and the physical page number into the set's least recently used way. The stage is ready in the next cycle, and a repeat of the access hits with the refilled data.
- R9: Each set keeps one replacement bit that reset points at way 0. A hit or a fill makes the way it used the most recent, so the other way becomes the next victim. A third page mapped to a full set evicts the page used least recently.
- R10: At most one way of a set matches any physical page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual byte address of the request |
| req_ready | output | 1 | Stage idle and able to accept a request |
| xlat_valid | input | 1 | Translation result present for the pending request |
| xlat_ppn | input | 17 | Physical page number from translation |
| xlat_fault | input | 1 | Translation reports a protection or mapping fault |
| resp_valid | output | 1 | Response present this cycle |
| resp_hit | output | 1 | The line is present; resp_data is valid |
| resp_fault | output | 1 | Access faulted during translation |
| resp_data | output | 32 | Requested word on a hit, zero otherwise |
| refill_req | output | 1 | Line refill wanted |
| refill_paddr | output | 32 | Line-aligned physical address of the refill |
| refill_valid | input | 1 | Refill line present on refill_data |
| refill_data | input | 512 | Full 64-byte refill line |

## Verification
The in-RTL properties watch the handshake on every cycle. A response never overlaps readiness, and a stall holds the latched offset. A fault never carries a hit and never leads to a refill. A miss is always followed by a refill request whose address stays stable until it is served. Fills never collide with reads, at most one way matches, and each replacement bit flips away from the way just used. The values themselves can only be shown by the bench scenarios run against its own model of tags and replacement bits: the returned word, the refill address, aliases of one physical page hitting one line, and the victim chosen after a mixed history of hits.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    localparam int DEF_VA_W   = 32;
    localparam int DEF_PPN_W  = 17;
    localparam int DEF_OFF_W  = 6;
    localparam int DEF_IDX_W  = 9;
    localparam int DEF_WORD_W = 32;
    localparam int NUM_WAYS   = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_FILL = 2'd2
    } look_state_e;
endpackage

// File: rtl/vipt_way.sv
module vipt_way #(
    parameter int IDX_W  = vipt_pkg::DEF_IDX_W,
    parameter int TAG_W  = vipt_pkg::DEF_PPN_W,
    parameter int LINE_W = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [LINE_W-1:0] line_mem [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (wr_en) valid_q[wr_idx] <= 1'b1;
            if (rd_en) rd_valid <= valid_q[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            line_mem[wr_idx] <= wr_line;
        end
        if (rd_en) begin
            rd_tag  <= tag_mem[rd_idx];
            rd_line <= line_mem[rd_idx];
        end
    end

    // R8: a fill never shares a cycle with a lookup read
    assert_fill_no_read_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_en));
endmodule

// File: rtl/vipt_lru.sv
module vipt_lru #(
    parameter int IDX_W = vipt_pkg::DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way,
    input  logic [IDX_W-1:0] q_idx,
    output logic             victim
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0] repl_q;

    always_ff @(posedge clk) begin
        if (rst) repl_q <= '0;
        else if (upd_en) repl_q[upd_idx] <= ~upd_way;
    end

    assign victim = repl_q[q_idx];

    // R9: after a use, the same set names the other way as victim
    assert_lru_flip_R9: assert property (@(posedge clk) disable iff (rst)
        (upd_en && q_idx == upd_idx) |=> (!$stable(q_idx) || victim != $past(upd_way)));
endmodule

// File: rtl/vipt_tag_match.sv
module vipt_tag_match #(
    parameter int TAG_W = vipt_pkg::DEF_PPN_W,
    parameter int WAYS  = vipt_pkg::NUM_WAYS
) (
    input  logic [WAYS-1:0]  way_valid,
    input  logic [TAG_W-1:0] way_tag [WAYS],
    input  logic [TAG_W-1:0] phys_tag,
    output logic [WAYS-1:0]  way_hit,
    output logic             any_hit,
    output logic             hit_way
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = way_valid[w] && (way_tag[w] == phys_tag);
    end

    assign any_hit = |way_hit;

    always_comb begin
        hit_way = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) hit_way = 1'(w);
        end
    end
endmodule

// File: rtl/vipt_cache_lookup.sv
module vipt_cache_lookup #(
    parameter int VA_W   = vipt_pkg::DEF_VA_W,
    parameter int PPN_W  = vipt_pkg::DEF_PPN_W,
    parameter int OFF_W  = vipt_pkg::DEF_OFF_W,
    parameter int IDX_W  = vipt_pkg::DEF_IDX_W,
    parameter int WORD_W = vipt_pkg::DEF_WORD_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            req_valid,
    input  logic [VA_W-1:0]                 req_vaddr,
    output logic                            req_ready,
    input  logic                            xlat_valid,
    input  logic [PPN_W-1:0]                xlat_ppn,
    input  logic                            xlat_fault,
    output logic                            resp_valid,
    output logic                            resp_hit,
    output logic                            resp_fault,
    output logic [WORD_W-1:0]               resp_data,
    output logic                            refill_req,
    output logic [PPN_W+IDX_W+OFF_W-1:0]    refill_paddr,
    input  logic                            refill_valid,
    input  logic [(8<<OFF_W)-1:0]           refill_data
);
    import vipt_pkg::*;

    localparam int WAYS   = NUM_WAYS;
    localparam int PAGE_W = IDX_W + OFF_W;
    localparam int LINE_W = 8 << OFF_W;
    localparam int BSEL_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = OFF_W - BSEL_W;

    look_state_e       state_q;
    logic [PAGE_W-1:0] off_q;
    logic [PPN_W-1:0]  ppn_q;

    logic accept, look_active, fill_fire;
    logic any_hit, hit_way, victim;
    logic [IDX_W-1:0]  req_idx, look_idx;
    logic [WSEL_W-1:0] word_sel;
    logic [WAYS-1:0]   rd_valid, way_hit, wr_en;
    logic [PPN_W-1:0]  rd_tag  [WAYS];
    logic [LINE_W-1:0] rd_line [WAYS];
    logic [LINE_W-1:0] sel_line;
    logic              unused_bits;

    assign req_idx     = req_vaddr[OFF_W +: IDX_W];
    assign look_idx    = off_q[OFF_W +: IDX_W];
    assign word_sel    = off_q[BSEL_W +: WSEL_W];
    assign unused_bits = ^{req_vaddr[VA_W-1:PAGE_W], off_q[BSEL_W-1:0]};

    assign req_ready   = (state_q == ST_IDLE);
    assign accept      = req_valid && req_ready;
    assign look_active = (state_q == ST_LOOK) && xlat_valid;
    assign fill_fire   = (state_q == ST_FILL) && refill_valid;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign wr_en[w] = fill_fire && (victim == 1'(w));
        vipt_way #(.IDX_W(IDX_W), .TAG_W(PPN_W), .LINE_W(LINE_W)) u_way (
            .clk      (clk),
            .rst      (rst),
            .rd_en    (accept),
            .rd_idx   (req_idx),
            .wr_en    (wr_en[w]),
            .wr_idx   (look_idx),
            .wr_tag   (ppn_q),
            .wr_line  (refill_data),
            .rd_valid (rd_valid[w]),
            .rd_tag   (rd_tag[w]),
            .rd_line  (rd_line[w])
        );
    end

    vipt_tag_match #(.TAG_W(PPN_W), .WAYS(WAYS)) u_match (
        .way_valid (rd_valid),
        .way_tag   (rd_tag),
        .phys_tag  (xlat_ppn),
        .way_hit   (way_hit),
        .any_hit   (any_hit),
        .hit_way   (hit_way)
    );

    vipt_lru #(.IDX_W(IDX_W)) u_lru (
        .clk     (clk),
        .rst     (rst),
        .upd_en  ((look_active && !xlat_fault && any_hit) || fill_fire),
        .upd_idx (look_idx),
        .upd_way (fill_fire ? victim : hit_way),
        .q_idx   (look_idx),
        .victim  (victim)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            off_q   <= '0;
            ppn_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_LOOK;
                    off_q   <= req_vaddr[PAGE_W-1:0];
                end
                ST_LOOK: if (xlat_valid) begin
                    ppn_q   <= xlat_ppn;
                    state_q <= (xlat_fault || any_hit) ? ST_IDLE : ST_FILL;
                end
                ST_FILL: if (refill_valid) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sel_line = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) sel_line = rd_line[w];
        end
    end

    assign resp_valid   = look_active;
    assign resp_fault   = look_active && xlat_fault;
    assign resp_hit     = look_active && !xlat_fault && any_hit;
    assign resp_data    = resp_hit ? sel_line[word_sel*WORD_W +: WORD_W] : '0;
    assign refill_req   = (state_q == ST_FILL);
    assign refill_paddr = {ppn_q, look_idx, {OFF_W{1'b0}}};

    // R4: a response never coincides with readiness for a new request
    assert_resp_not_ready_R4: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !req_ready);
    // R4: a pending translation keeps the stage in lookup with the offset held
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOK && !xlat_valid) |=> (state_q == ST_LOOK && $stable(off_q)));
    // R6: a fault carries no hit
    assert_fault_no_hit_R6: assert property (@(posedge clk) disable iff (rst)
        resp_fault |-> !resp_hit);
    // R6: a fault never starts a refill
    assert_fault_no_refill_R6: assert property (@(posedge clk) disable iff (rst)
        resp_fault |=> (!refill_req && req_ready));
    // R7: a miss is followed by a refill request
    assert_miss_refill_R7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit && !resp_fault) |=> refill_req);
    // R7: an unserved refill keeps its request and address
    assert_refill_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (refill_req && !refill_valid) |=> (refill_req && $stable(refill_paddr)));
    // R10: no set holds the same physical page in two ways
    assert_one_way_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOK) |-> $onehot0(way_hit));
endmodule

// File: tb/vipt_cache_lookup_tb.sv
`timescale 1ns/1ps
module vipt_cache_lookup_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [31:0]  req_vaddr;
    logic         req_ready;
    logic         xlat_valid;
    logic [16:0]  xlat_ppn;
    logic         xlat_fault;
    logic         resp_valid, resp_hit, resp_fault;
    logic [31:0]  resp_data;
    logic         refill_req;
    logic [31:0]  refill_paddr;
    logic         refill_valid;
    logic [511:0] refill_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    bit          m_valid [2][512];
    logic [16:0] m_tag   [2][512];
    bit          m_repl  [512];

    always #2.5 clk = ~clk;

    vipt_cache_lookup u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_ready(req_ready), .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn),
        .xlat_fault(xlat_fault), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_fault(resp_fault), .resp_data(resp_data), .refill_req(refill_req),
        .refill_paddr(refill_paddr), .refill_valid(refill_valid), .refill_data(refill_data)
    );

    function automatic logic [31:0] line_word(input logic [31:0] pa, input int k);
        return pa ^ (32'(k) * 32'h9E37_79B9) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [511:0] make_line(input logic [31:0] pa);
        logic [511:0] v;
        for (int k = 0; k < 16; k++) v[k*32 +: 32] = line_word(pa, k);
        return v;
    endfunction

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] va, input logic [16:0] ppn, input bit fault,
                          input int xdelay, input int fdelay, input string rq_hit);
        int   idx;
        int   hw;
        bit   exp_hit;
        logic [31:0] line_pa;
        idx     = int'(va[14:6]);
        exp_hit = 1'b0;
        hw      = 0;
        for (int w = 0; w < 2; w++)
            if (m_valid[w][idx] && m_tag[w][idx] == ppn) begin exp_hit = 1'b1; hw = w; end
        if (fault) exp_hit = 1'b0;
        line_pa = {ppn, va[14:6], 6'b0};

        @(negedge clk);
        check(req_ready == 1'b1, "R3 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        for (int d = 0; d < xdelay; d++) begin
            check(resp_valid == 1'b0 && req_ready == 1'b0, "R4 stall",
                  64'({resp_valid, req_ready}), 64'd0);
            @(negedge clk);
        end
        xlat_valid = 1'b1;
        xlat_ppn   = ppn;
        xlat_fault = fault;
        #1;
        check(resp_valid == 1'b1, "R3 response with translation", 64'(resp_valid), 64'd1);
        check(resp_fault == fault, "R6 fault flag", 64'(resp_fault), 64'(fault));
        check(resp_hit == exp_hit, rq_hit, 64'(resp_hit), 64'(exp_hit));
        if (exp_hit)
            check(resp_data == line_word(line_pa, int'(va[5:2])), "R2 returned word",
                  64'(resp_data), 64'(line_word(line_pa, int'(va[5:2]))));
        @(negedge clk);
        xlat_valid = 1'b0;
        xlat_fault = 1'b0;
        if (fault) begin
            check(refill_req == 1'b0 && req_ready == 1'b1, "R6 no refill after fault",
                  64'({refill_req, req_ready}), 64'd1);
        end else if (exp_hit) begin
            m_repl[idx] = ~1'(hw);
            check(req_ready == 1'b1, "R3 ready after hit", 64'(req_ready), 64'd1);
        end else begin
            check(refill_req == 1'b1 && req_ready == 1'b0, "R7 refill requested",
                  64'({refill_req, req_ready}), 64'd2);
            check(refill_paddr == line_pa, "R7 refill address", 64'(refill_paddr), 64'(line_pa));
            for (int d = 0; d < fdelay; d++) begin
                @(negedge clk);
                check(refill_req == 1'b1 && refill_paddr == line_pa, "R7 refill held",
                      64'(refill_paddr), 64'(line_pa));
            end
            refill_valid = 1'b1;
            refill_data  = make_line(line_pa);
            @(negedge clk);
            refill_valid = 1'b0;
            check(req_ready == 1'b1 && refill_req == 1'b0, "R8 ready after fill",
                  64'({req_ready, refill_req}), 64'd2);
            hw = int'(m_repl[idx]);
            m_valid[hw][idx] = 1'b1;
            m_tag[hw][idx]   = ppn;
            m_repl[idx]      = ~m_repl[idx];
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                report();
            end
        end
    end

    initial begin
        logic [31:0] va;
        logic [16:0] pool [5];
        int          sets [4];
        void'($urandom(32'd2024));
        for (int s = 0; s < 512; s++) begin
            m_valid[0][s] = 0; m_valid[1][s] = 0; m_repl[s] = 0;
        end
        rst = 1'b1; req_valid = 0; req_vaddr = '0; xlat_valid = 0; xlat_ppn = '0;
        xlat_fault = 0; refill_valid = 0; refill_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && resp_valid == 1'b0 && refill_req == 1'b0, "R1 reset outputs",
              64'({req_ready, resp_valid, refill_req}), 64'd4);

        // R1: empty cache misses; R8: refill then hit with data
        access(32'h0000_127C, 17'h00ABC, 0, 0, 2, "R1 first access misses");
        access(32'h0000_127C, 17'h00ABC, 0, 0, 0, "R8 hit after fill");
        access(32'h0000_1240, 17'h00ABC, 0, 1, 0, "R2 other word same line");
        // R5: alias with different virtual page, same physical page
        access(32'h5A5A_127C, 17'h00ABC, 0, 0, 0, "R5 alias hits same line");
        access(32'hFFFF_9260, 17'h00ABC, 0, 0, 0, "R5 second alias hits");
        // R5: same virtual address, other physical page misses
        access(32'h0000_127C, 17'h01111, 0, 0, 1, "R5 other page misses");
        // R9: use page A, bring page C: page B is evicted
        access(32'h0000_127C, 17'h00ABC, 0, 0, 0, "R9 page A resident");
        access(32'h0000_127C, 17'h12345, 0, 0, 0, "R9 third page misses");
        access(32'h0000_127C, 17'h00ABC, 0, 0, 0, "R9 recent page kept");
        access(32'h0000_127C, 17'h01111, 0, 0, 0, "R9 old page evicted");
        // R6: fault on a resident line
        access(32'h0000_127C, 17'h00ABC, 1, 0, 0, "R6 fault hides hit");
        access(32'h0000_127C, 17'h00ABC, 0, 4, 0, "R4 long stall then hit");
        // R2: set index taken from bits 14:6
        access(32'h0000_7FC4, 17'h00ABC, 0, 0, 0, "R2 top set misses");
        access(32'h0000_7FC4, 17'h00ABC, 0, 0, 0, "R2 top set hits");

        pool[0] = 17'h00ABC; pool[1] = 17'h01111; pool[2] = 17'h12345;
        pool[3] = 17'h1FFFF; pool[4] = 17'h00000;
        sets[0] = 9'h049; sets[1] = 9'h1FF; sets[2] = 9'h000; sets[3] = 9'h0AA;
        for (int i = 0; i < 400; i++) begin
            va = $urandom;
            va[14:6] = 9'(sets[$urandom_range(0, 3)]);
            access(va, pool[$urandom_range(0, 4)], ($urandom_range(0, 15) == 0),
                   $urandom_range(0, 2), $urandom_range(0, 3), "R5 R10 random hit status");
        end
        report();
    end
endmodule